// File: doc/BRIEF.md
# Tagged Associative Translation Buffer

This block keeps a small set of recently used page-table entries and turns a 24-bit virtual address into a 32-bit physical address in a single clock. The upper 11 bits of the virtual address select a page; the lower 13 bits are a byte offset that passes through unchanged. Every entry holds a page number, a process tag, a 19-bit frame number and four status flags. All entries are compared against the requested page at once. A match counts only when the entry is valid and its process tag equals the current process id.

A lookup that finds nothing raises a miss and changes nothing. Logic outside the block then walks the page table and writes the entry through the refill port. A write lookup that lands on a read-only entry reports a protection fault. On a context switch the maintenance port can either wipe the whole buffer back to its reset state or drop only the valid bits.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup hits only when a valid entry has a page number equal to `lk_vaddr[23:13]` and a process tag equal to `cur_pid`. An entry that differs in either field does not hit.
- R2: On a hit, `rsp_paddr` equals the stored 19-bit frame number in bits 31..13, followed by `lk_vaddr[12:0]` in bits 12..0.
- R3: When no entry matches, `rsp_miss` is 1, `rsp_hit` and `rsp_prot` are 0, and `rsp_paddr` and `rsp_flags` are 0.
- R4: A write lookup (`lk_write`=1) that matches an entry whose writable flag is clear gives `rsp_prot`=1, not a hit. In that case `rsp_paddr` is 0, `rsp_flags` shows the stored flags, and the entry's dirty flag stays clear.
- R5: `rsp_flags` uses bit 3 for dirty, bit 2 for referenced, bit 1 for writable and bit 0 for valid. Any hit sets the entry's referenced flag, and a write hit also sets its dirty flag. A hit reports the flags as they stand after that update.
- R6: A refill that matches no existing entry goes to the lowest-numbered invalid slot. It becomes valid with the given frame and flags, and a lookup in the very next cycle sees it.
- R7: A refill whose page number and process tag equal those of a valid entry overwrites that entry, so later lookups return the new frame.
- R8: When every slot is valid, a refill replaces the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, after each such replacement.
- R9: `mt_flush` makes every entry invalid, clears all flags and returns the round-robin pointer to 0.
- R10: `mt_inval` clears only the valid bits. The round-robin pointer keeps its value.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1. When it is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_prot` is 1.
- R12: After reset every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_prot` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 24 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| cur_pid | input | 8 | Current process id compared with the entry tags |
| rf_valid | input | 1 | Write one entry this cycle |
| rf_vpn | input | 11 | Page number of the new entry |
| rf_pid | input | 8 | Process tag of the new entry |
| rf_frame | input | 19 | Frame number of the new entry |
| rf_writable | input | 1 | Writable flag of the new entry |
| rf_dirty | input | 1 | Dirty flag of the new entry |
| rf_refd | input | 1 | Referenced flag of the new entry |
| mt_flush | input | 1 | Empty the buffer and reset the replacement pointer |
| mt_inval | input | 1 | Clear only the valid bits |
| rsp_valid | output | 1 | A lookup result is presented |
| rsp_hit | output | 1 | The lookup translated |
| rsp_miss | output | 1 | No entry matched |
| rsp_prot | output | 1 | A store matched a read-only entry |
| rsp_paddr | output | 32 | Physical address on a hit, otherwise 0 |
| rsp_flags | output | 4 | Entry flags {dirty, referenced, writable, valid} |

## Verification
Every lookup result is registered and appears on the outputs one clock after the edge that samples the request. An entry written by refill, and the effect of a flush or an invalidate, is visible to a lookup driven in the following cycle. The bench changes inputs on the falling edge and holds a lookup for exactly one rising edge. It reads the result at the next falling edge, which falls inside the single cycle in which the result is valid. Replacement order is observed only through which pages miss afterwards. This is how the bench tells the two clear modes apart: after each one it fills the buffer completely and checks which slot the next refill evicts.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Status bits kept per entry, packed in the order reported on rsp_flags.
  typedef struct packed {
    logic dirty;
    logic refd;
    logic wr;
    logic vld;
  } tlb_flags_t;

  localparam int FLAG_W = $bits(tlb_flags_t);

endpackage

// File: rtl/tlb_first.sv
// Lowest-index set bit of a vector, plus an any-set flag.
module tlb_first #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/tlb_tags.sv
// Per-entry page/process tags with two parallel comparator banks:
// one for lookups and one for duplicate detection on refill.
module tlb_tags #(
  parameter int N     = 64,
  parameter int PN_W  = 11,
  parameter int PID_W = 8,
  parameter int IW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [PN_W-1:0]  wpn,
  input  logic [PID_W-1:0] wpid,
  input  logic [PN_W-1:0]  lk_pn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [PN_W-1:0]  rf_pn,
  input  logic [PID_W-1:0] rf_pid,
  output logic [N-1:0]     lk_eq,
  output logic [N-1:0]     rf_eq
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [PN_W-1:0]  pn_q;
    logic [PID_W-1:0] pid_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        pn_q  <= '0;
        pid_q <= '0;
      end else if (we && widx == IW'(g)) begin
        pn_q  <= wpn;
        pid_q <= wpid;
      end
    end

    assign lk_eq[g] = (pn_q == lk_pn) && (pid_q == lk_pid);
    assign rf_eq[g] = (pn_q == rf_pn) && (pid_q == rf_pid);
  end

endmodule

// File: rtl/tlb_frame_ram.sv
// Frame-number store: one write port, one registered read port.
module tlb_frame_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 19,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 24,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic                    lk_write,
  input  logic [PID_W-1:0]        cur_pid,
  input  logic                    rf_valid,
  input  logic [VA_W-OFF_W-1:0]   rf_vpn,
  input  logic [PID_W-1:0]        rf_pid,
  input  logic [PA_W-OFF_W-1:0]   rf_frame,
  input  logic                    rf_writable,
  input  logic                    rf_dirty,
  input  logic                    rf_refd,
  input  logic                    mt_flush,
  input  logic                    mt_inval,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_miss,
  output logic                    rsp_prot,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic [FLAG_W-1:0]       rsp_flags
);

  localparam int PN_W = VA_W - OFF_W;
  localparam int FN_W = PA_W - OFF_W;
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, dirty_q, refd_q, wr_q;
  logic [ENTRIES-1:0] lk_eq, rf_eq, lk_hitv, rf_hitv;
  logic [IW-1:0]      lk_idx, dup_idx, free_idx, victim, rr_q;
  logic               lk_any, dup_any, free_any;
  logic               maint, rf_do, use_rr, lk_ok, lk_bad;
  logic [PN_W-1:0]    lk_pn;

  logic               hit_q, miss_q, prot_q, rv_q;
  logic [OFF_W-1:0]   off_q;
  tlb_flags_t         flags_q;
  logic [FN_W-1:0]    frame_rd;

  assign lk_pn = lk_vaddr[VA_W-1:OFF_W];

  tlb_tags #(
    .N(ENTRIES), .PN_W(PN_W), .PID_W(PID_W), .IW(IW)
  ) u_tags (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_do),
    .widx   (victim),
    .wpn    (rf_vpn),
    .wpid   (rf_pid),
    .lk_pn  (lk_pn),
    .lk_pid (cur_pid),
    .rf_pn  (rf_vpn),
    .rf_pid (rf_pid),
    .lk_eq  (lk_eq),
    .rf_eq  (rf_eq)
  );

  assign lk_hitv = lk_eq & valid_q;
  assign rf_hitv = rf_eq & valid_q;

  tlb_first #(.N(ENTRIES), .IW(IW)) u_lk_enc (
    .vec (lk_hitv), .idx (lk_idx), .any (lk_any)
  );
  tlb_first #(.N(ENTRIES), .IW(IW)) u_dup_enc (
    .vec (rf_hitv), .idx (dup_idx), .any (dup_any)
  );
  tlb_first #(.N(ENTRIES), .IW(IW)) u_free_enc (
    .vec (~valid_q), .idx (free_idx), .any (free_any)
  );

  // Refill slot choice: existing copy, then lowest free slot, then rotation.
  always_comb begin
    use_rr = 1'b0;
    if (dup_any)       victim = dup_idx;
    else if (free_any) victim = free_idx;
    else begin
      victim = rr_q;
      use_rr = 1'b1;
    end
  end

  assign maint  = mt_flush | mt_inval;
  assign rf_do  = rf_valid & ~maint;
  assign lk_bad = lk_valid & lk_any & lk_write & ~wr_q[lk_idx];
  assign lk_ok  = lk_valid & lk_any & ~lk_bad;

  // Entry status state; maintenance overrides refill and lookup updates.
  always_ff @(posedge clk) begin
    if (rst || mt_flush) begin
      valid_q <= '0;
      dirty_q <= '0;
      refd_q  <= '0;
      wr_q    <= '0;
      rr_q    <= '0;
    end else if (mt_inval) begin
      valid_q <= '0;
    end else begin
      if (lk_ok) begin
        refd_q[lk_idx] <= 1'b1;
        if (lk_write) dirty_q[lk_idx] <= 1'b1;
      end
      if (rf_do) begin
        valid_q[victim] <= 1'b1;
        dirty_q[victim] <= rf_dirty;
        refd_q[victim]  <= rf_refd;
        wr_q[victim]    <= rf_writable;
        if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
    end
  end

  tlb_frame_ram #(.DEPTH(ENTRIES), .W(FN_W), .AW(IW)) u_frames (
    .clk   (clk),
    .we    (rf_do),
    .waddr (victim),
    .wdata (rf_frame),
    .raddr (lk_idx),
    .rdata (frame_rd)
  );

  // Registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q    <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      prot_q  <= 1'b0;
      off_q   <= '0;
      flags_q <= '0;
    end else begin
      rv_q   <= lk_valid;
      hit_q  <= lk_ok;
      miss_q <= lk_valid & ~lk_any;
      prot_q <= lk_bad;
      off_q  <= lk_vaddr[OFF_W-1:0];
      if (lk_valid && lk_any) begin
        flags_q.dirty <= dirty_q[lk_idx] | (lk_ok & lk_write);
        flags_q.refd  <= refd_q[lk_idx] | lk_ok;
        flags_q.wr    <= wr_q[lk_idx];
        flags_q.vld   <= 1'b1;
      end else begin
        flags_q <= '0;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = hit_q;
  assign rsp_miss  = miss_q;
  assign rsp_prot  = prot_q;
  assign rsp_flags = flags_q;
  assign rsp_paddr = hit_q ? {frame_rd, off_q} : '0;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W    = 24,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_valid,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  lk_write,
  input logic                  mt_flush,
  input logic                  mt_inval,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic                  rsp_miss,
  input logic                  rsp_prot,
  input logic [PA_W-1:0]       rsp_paddr,
  input logic [3:0]            rsp_flags
);

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot}) == 1);

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

  assert_hit_marks_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_flags[2] && rsp_flags[0] && (rsp_flags[3] || !$past(lk_write)));

  assert_prot_only_store_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_prot |-> $past(lk_write) && rsp_flags[1:0] == 2'b01);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    mt_flush ##1 lk_valid |=> !rsp_hit && !rsp_prot);

  assert_inval_empties_R10: assert property (@(posedge clk) disable iff (rst)
    mt_inval ##1 lk_valid |=> !rsp_hit && !rsp_prot);

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PID_W(PID_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .lk_write  (lk_write),
  .mt_flush  (mt_flush),
  .mt_inval  (mt_inval),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_prot  (rsp_prot),
  .rsp_paddr (rsp_paddr),
  .rsp_flags (rsp_flags)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [23:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic        rf_valid = 1'b0;
  logic [10:0] rf_vpn = '0;
  logic [7:0]  rf_pid = '0;
  logic [18:0] rf_frame = '0;
  logic        rf_writable = 1'b0;
  logic        rf_dirty = 1'b0;
  logic        rf_refd = 1'b0;
  logic        mt_flush = 1'b0;
  logic        mt_inval = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_flags;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .cur_pid(cur_pid), .rf_valid(rf_valid),
    .rf_vpn(rf_vpn), .rf_pid(rf_pid), .rf_frame(rf_frame),
    .rf_writable(rf_writable), .rf_dirty(rf_dirty), .rf_refd(rf_refd),
    .mt_flush(mt_flush), .mt_inval(mt_inval), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot),
    .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [18:0] fr(input logic [10:0] pn, input logic [7:0] salt);
    return {salt, pn};
  endfunction

  // Drive one lookup for one rising edge; result is readable on return.
  task automatic lookup(input logic [10:0] pn, input logic [12:0] off,
                        input logic [7:0] pid, input logic wr);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = {pn, off};
    lk_write = wr;
    cur_pid  = pid;
    @(negedge clk);
    lk_valid = 1'b0;
    lk_write = 1'b0;
  endtask

  task automatic refill(input logic [10:0] pn, input logic [7:0] pid,
                        input logic [18:0] frame, input logic w,
                        input logic d, input logic r);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = pn; rf_pid = pid; rf_frame = frame;
    rf_writable = w; rf_dirty = d; rf_refd = r;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic maint(input logic fl, input logic inv);
    @(negedge clk);
    mt_flush = fl; mt_inval = inv;
    @(negedge clk);
    mt_flush = 1'b0; mt_inval = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [10:0] pn, input logic [12:0] off,
                            input logic [7:0] pid, input logic wr,
                            input logic [18:0] frame, input logic [3:0] flags);
    lookup(pn, off, pid, wr);
    check({tag, " hit"}, rsp_hit, 1'b1);
    check({tag, " paddr"}, rsp_paddr, {frame, off});
    check({tag, " flags"}, rsp_flags, flags);
  endtask

  task automatic expect_miss(input string tag, input logic [10:0] pn, input logic [7:0] pid);
    lookup(pn, 13'h0155, pid, 1'b0);
    check({tag, " miss"}, rsp_miss, 1'b1);
    check({tag, " no hit"}, rsp_hit, 1'b0);
    check({tag, " paddr zero"}, rsp_paddr, 32'h0);
  endtask

  task automatic fill_all(input logic [10:0] base, input logic [7:0] salt);
    for (int i = 0; i < N; i++)
      refill(base + 11'(i), 8'h01, fr(base + 11'(i), salt), 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R12 rsp_valid after reset", rsp_valid, 1'b0);
    check("R12 outcome bits after reset", {rsp_hit, rsp_miss, rsp_prot}, 3'b000);
    expect_miss("R12 empty buffer", 11'd5, 8'h03);
    check("R11 rsp_valid with lookup", rsp_valid, 1'b1);
    @(negedge clk);
    check("R11 rsp_valid idle", rsp_valid, 1'b0);
  endtask

  task automatic t_basic;
    refill(11'd5, 8'h03, 19'h1234A, 1'b1, 1'b0, 1'b0);
    expect_hit("R6 R2 read", 11'd5, 13'h0ABC, 8'h03, 1'b0, 19'h1234A, 4'b0111);
    expect_miss("R1 other pid", 11'd5, 8'h04);
    expect_miss("R3 other page", 11'd6, 8'h03);
    check("R3 flags zero", rsp_flags, 4'h0);
    expect_hit("R5 write hit", 11'd5, 13'h1FFF, 8'h03, 1'b1, 19'h1234A, 4'b1111);
    expect_hit("R5 dirty held", 11'd5, 13'h0000, 8'h03, 1'b0, 19'h1234A, 4'b1111);
  endtask

  task automatic t_prot;
    refill(11'd9, 8'h03, 19'h00777, 1'b0, 1'b0, 1'b0);
    lookup(11'd9, 13'h0010, 8'h03, 1'b1);
    check("R4 prot", rsp_prot, 1'b1);
    check("R4 no hit", rsp_hit, 1'b0);
    check("R4 paddr zero", rsp_paddr, 32'h0);
    check("R4 stored flags", rsp_flags, 4'b0001);
    expect_hit("R4 dirty unset", 11'd9, 13'h0010, 8'h03, 1'b0, 19'h00777, 4'b0101);
  endtask

  task automatic t_dup;
    refill(11'd5, 8'h03, 19'h55555, 1'b1, 1'b0, 1'b0);
    expect_hit("R7 overwritten frame", 11'd5, 13'h0123, 8'h03, 1'b0, 19'h55555, 4'b0111);
    refill(11'd5, 8'h04, 19'h22222, 1'b1, 1'b0, 1'b0);
    expect_hit("R1 pid4 entry", 11'd5, 13'h0040, 8'h04, 1'b0, 19'h22222, 4'b0111);
    expect_hit("R7 pid3 entry kept", 11'd5, 13'h0040, 8'h03, 1'b0, 19'h55555, 4'b0111);
  endtask

  task automatic t_rotation;
    maint(1'b1, 1'b0);
    expect_miss("R9 flush clears", 11'd5, 8'h03);
    fill_all(11'd100, 8'h11);
    expect_hit("R6 full set", 11'd163, 13'h0001, 8'h01, 1'b0, fr(11'd163, 8'h11), 4'b0111);
    refill(11'd300, 8'h01, fr(11'd300, 8'h22), 1'b1, 1'b0, 1'b0);
    expect_miss("R8 R6 slot0 evicted", 11'd100, 8'h01);
    expect_hit("R8 slot1 kept", 11'd101, 13'h0002, 8'h01, 1'b0, fr(11'd101, 8'h11), 4'b0111);
    expect_hit("R8 new entry", 11'd300, 13'h0003, 8'h01, 1'b0, fr(11'd300, 8'h22), 4'b0111);
    refill(11'd301, 8'h01, fr(11'd301, 8'h22), 1'b1, 1'b0, 1'b0);
    expect_miss("R8 slot1 evicted", 11'd101, 8'h01);
    expect_hit("R8 slot2 kept", 11'd102, 13'h0004, 8'h01, 1'b0, fr(11'd102, 8'h11), 4'b0111);

    maint(1'b0, 1'b1);
    expect_miss("R10 inval clears", 11'd300, 8'h01);
    fill_all(11'd400, 8'h33);
    refill(11'd600, 8'h01, fr(11'd600, 8'h44), 1'b1, 1'b0, 1'b0);
    expect_miss("R10 pointer kept slot2", 11'd402, 8'h01);
    expect_hit("R10 slot0 kept", 11'd400, 13'h0005, 8'h01, 1'b0, fr(11'd400, 8'h33), 4'b0111);
    expect_hit("R10 slot1 kept", 11'd401, 13'h0006, 8'h01, 1'b0, fr(11'd401, 8'h33), 4'b0111);

    maint(1'b1, 1'b0);
    expect_miss("R9 flush clears again", 11'd600, 8'h01);
    fill_all(11'd700, 8'h55);
    refill(11'd900, 8'h01, fr(11'd900, 8'h66), 1'b1, 1'b0, 1'b0);
    expect_miss("R9 pointer reset slot0", 11'd700, 8'h01);
    expect_hit("R9 slot2 kept", 11'd702, 13'h0007, 8'h01, 1'b0, fr(11'd702, 8'h55), 4'b0111);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prot();
    t_dup();
    t_rotation();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R11 watchdog: actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule